// File: doc/BRIEF.md
# Integer add unit with flags

This block is the addition stage of a 32-bit execute unit. It accepts an instruction word together with two register operand values and the current carry, compare-flag and overflow-trap-enable status bits. It recognises four add forms: register plus register, register plus register plus carry, register plus sign-extended 16-bit immediate, and the same immediate form with carry. For an accepted add it produces the destination index, the 32-bit sum and the next carry, overflow and compare-flag values. When the signed result overflows while overflow trapping is enabled, it raises a one-cycle range-exception request that carries the offending instruction word.

All results are registered together one clock after a valid input. A small state register records what kind of result the output stage holds. ST_IDLE means nothing was accepted. ST_DONE means an add completed without a trap. ST_TRAP means an add completed and requested a range exception. ST_REJECT means the instruction was not one of the four add forms. On every clock the state is chosen from the current input. A low valid selects ST_IDLE. A valid non-add selects ST_REJECT. A valid add whose overflow meets a set trap enable selects ST_TRAP. Any other valid add selects ST_DONE. All states can reach all others, so results can follow back to back.

Top module: `int_add_unit`

## Requirements
- R1: The opcode is bits [31:26] of the instruction and the destination index is bits [25:21]. Opcode 0x27 selects the immediate add and 0x28 the immediate add with carry. Opcode 0x38 with bits [9:8] equal to 0 selects a register form: bits [3:0] equal to 0x0 give the plain add and 0x1 give the add with carry. For example 0xE0853000 writes r4 with the sum of the two operand inputs.
- R2: The immediate forms take the second operand from bits [15:0] of the instruction, sign-extended to 32 bits (0x8000 becomes 0xFFFF8000, 0xFFFF becomes 0xFFFFFFFF), and ignore the second operand input.
- R3: Only the two with-carry forms add the incoming carry status bit; a set carry bit has no effect on the plain register and plain immediate forms (1+2 gives 3 with carry clear).
- R4: Overflow is 1 exactly when both operands have the same sign and the result sign differs from it, with the carry-in included in the result.
- R5: Carry is 1 exactly when the unsigned sum of both operands and the carry-in exceeds 0xFFFFFFFF, so 0xFFFFFFFF+0+1 and 0+0xFFFFFFFF+1 both give 0 with carry set.
- R6: When the flag-enable input is 1 an add sets the compare flag if its result is 0 and clears it otherwise; when the flag-enable input is 0 the compare flag takes the incoming compare-flag value.
- R7: The trap strobe is 1 for one cycle, with the instruction word on the cause output, only when an add produces overflow while the trap-enable input is 1. A carry alone never raises it, and the register write and flag update still take place.
- R8: The result, destination, flags, write strobe and trap strobe all appear one clock edge after a valid input. While valid is low no write, flag update, trap or reject is signalled and the flag outputs hold.
- R9: A valid instruction outside the four add forms gives a one-cycle unsupported strobe, no register write, no flag update and unchanged flag outputs.
- R10: After reset every strobe is 0 and the result, destination, flags and cause outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| in_insn | input | 32 | Instruction word |
| in_opa | input | 32 | First register operand value |
| in_opb | input | 32 | Second register operand value (register forms only) |
| in_sr_cy | input | 1 | Current carry status bit |
| in_sr_f | input | 1 | Current compare-flag status bit |
| in_sr_ove | input | 1 | Overflow trap enable status bit |
| in_flag_en | input | 1 | Arithmetic compare-flag update enable |
| out_wr_en | output | 1 | Destination register write strobe |
| out_rd | output | 5 | Destination register index |
| out_result | output | 32 | Sum to be written |
| out_flag_we | output | 1 | Status flag update strobe |
| out_sr_cy | output | 1 | Next carry bit |
| out_sr_ov | output | 1 | Next overflow bit |
| out_sr_f | output | 1 | Next compare-flag bit |
| out_trap | output | 1 | Range-exception request strobe |
| out_trap_insn | output | 32 | Instruction word causing the exception, 0 when no request |
| out_unsup | output | 1 | Unsupported instruction strobe |

## Verification
Every result of this block is due exactly one rising edge after the cycle in which its input was driven, including the unsupported strobe, the trap strobe and its cause word. The driver places inputs at a falling edge and queues the expected outputs for that item, idle cycles included. The monitor removes one queued item per rising edge and compares it a short delay after that edge, so each check lands in the single cycle where its result is valid and no later one.

// File: rtl/iadd_pkg.sv
package iadd_pkg;

    // Major opcodes of the add forms
    localparam logic [5:0] OPC_ADDI  = 6'h27;
    localparam logic [5:0] OPC_ADDIC = 6'h28;
    localparam logic [5:0] OPC_ALU   = 6'h38;

    // Register-form sub-operation codes (bits [3:0], with bits [9:8] zero)
    localparam logic [1:0] SUB_HI_ADD = 2'b00;
    localparam logic [3:0] SUB_ADD    = 4'h0;
    localparam logic [3:0] SUB_ADDC   = 4'h1;

    // What the output stage holds
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DONE   = 2'd1,
        ST_TRAP   = 2'd2,
        ST_REJECT = 2'd3
    } iadd_state_e;

endpackage

// File: rtl/iadd_decode.sv
module iadd_decode
    import iadd_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [5:0]       opcode,
    input  logic [1:0]       sub_hi,
    input  logic [3:0]       sub_lo,
    input  logic [IMM_W-1:0] imm,
    output logic             is_add,
    output logic             use_imm,
    output logic             use_cin,
    output logic [XLEN-1:0]  imm_ext
);

    localparam int EXT_W = XLEN - IMM_W;

    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        is_add  = 1'b0;
        use_imm = 1'b0;
        use_cin = 1'b0;
        unique case (opcode)
            OPC_ADDI: begin
                is_add  = 1'b1;
                use_imm = 1'b1;
            end
            OPC_ADDIC: begin
                is_add  = 1'b1;
                use_imm = 1'b1;
                use_cin = 1'b1;
            end
            OPC_ALU: begin
                if (sub_hi == SUB_HI_ADD) begin
                    if (sub_lo == SUB_ADD) begin
                        is_add = 1'b1;
                    end else if (sub_lo == SUB_ADDC) begin
                        is_add  = 1'b1;
                        use_cin = 1'b1;
                    end
                end
            end
            default: begin
                is_add = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/iadd_sum.sv
module iadd_sum #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            carry,
    output logic            ovf
);

    localparam int MSB = XLEN - 1;

    logic [XLEN:0] wide;

    // The extra bit of the widened sum is the unsigned carry, which covers
    // the all-ones plus zero plus carry-in case without a compare.
    always_comb begin
        wide  = {1'b0, opa} + {1'b0, opb} + {{XLEN{1'b0}}, cin};
        sum   = wide[MSB:0];
        carry = wide[XLEN];
        ovf   = (opa[MSB] == opb[MSB]) && (sum[MSB] != opa[MSB]);
    end

endmodule

// File: rtl/int_add_unit.sv
module int_add_unit
    import iadd_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_insn,
    input  logic [XLEN-1:0]   in_opa,
    input  logic [XLEN-1:0]   in_opb,
    input  logic              in_sr_cy,
    input  logic              in_sr_f,
    input  logic              in_sr_ove,
    input  logic              in_flag_en,
    output logic              out_wr_en,
    output logic [RIDX_W-1:0] out_rd,
    output logic [XLEN-1:0]   out_result,
    output logic              out_flag_we,
    output logic              out_sr_cy,
    output logic              out_sr_ov,
    output logic              out_sr_f,
    output logic              out_trap,
    output logic [31:0]       out_trap_insn,
    output logic              out_unsup
);

    localparam int INSN_W  = 32;
    localparam int OPC_LSB = INSN_W - 6;
    localparam int RD_LSB  = OPC_LSB - RIDX_W;

    logic              dec_is_add;
    logic              dec_use_imm;
    logic              dec_use_cin;
    logic [XLEN-1:0]   dec_imm_ext;
    logic [XLEN-1:0]   opb_sel;
    logic              cin;
    logic [XLEN-1:0]   sum;
    logic              sum_cy;
    logic              sum_ov;
    logic              f_next;

    iadd_state_e       state_q;
    iadd_state_e       state_nx;

    logic [RIDX_W-1:0] rd_q;
    logic [XLEN-1:0]   result_q;
    logic              cy_q;
    logic              ov_q;
    logic              f_q;
    logic [INSN_W-1:0] insn_q;

    iadd_decode #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_decode (
        .opcode  (in_insn[INSN_W-1:OPC_LSB]),
        .sub_hi  (in_insn[9:8]),
        .sub_lo  (in_insn[3:0]),
        .imm     (in_insn[IMM_W-1:0]),
        .is_add  (dec_is_add),
        .use_imm (dec_use_imm),
        .use_cin (dec_use_cin),
        .imm_ext (dec_imm_ext)
    );

    assign opb_sel = dec_use_imm ? dec_imm_ext : in_opb;
    assign cin     = dec_use_cin & in_sr_cy;

    iadd_sum #(
        .XLEN (XLEN)
    ) u_sum (
        .opa   (in_opa),
        .opb   (opb_sel),
        .cin   (cin),
        .sum   (sum),
        .carry (sum_cy),
        .ovf   (sum_ov)
    );

    assign f_next = in_flag_en ? (sum == '0) : in_sr_f;

    // Next-state selection from the current input
    always_comb begin
        if (!in_valid) begin
            state_nx = ST_IDLE;
        end else if (!dec_is_add) begin
            state_nx = ST_REJECT;
        end else if (sum_ov && in_sr_ove) begin
            state_nx = ST_TRAP;
        end else begin
            state_nx = ST_DONE;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Result and flag registers, loaded only by an accepted add
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            result_q <= '0;
            cy_q     <= 1'b0;
            ov_q     <= 1'b0;
            f_q      <= 1'b0;
            insn_q   <= '0;
        end else if (in_valid && dec_is_add) begin
            rd_q     <= in_insn[OPC_LSB-1:RD_LSB];
            result_q <= sum;
            cy_q     <= sum_cy;
            ov_q     <= sum_ov;
            f_q      <= f_next;
            insn_q   <= in_insn;
        end
    end

    assign out_rd     = rd_q;
    assign out_result = result_q;
    assign out_sr_cy  = cy_q;
    assign out_sr_ov  = ov_q;
    assign out_sr_f   = f_q;

    // Strobes decoded from the held state
    always_comb begin
        out_wr_en     = 1'b0;
        out_flag_we   = 1'b0;
        out_trap      = 1'b0;
        out_trap_insn = '0;
        out_unsup     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                out_wr_en = 1'b0;
            end
            ST_DONE: begin
                out_wr_en   = 1'b1;
                out_flag_we = 1'b1;
            end
            ST_TRAP: begin
                out_wr_en     = 1'b1;
                out_flag_we   = 1'b1;
                out_trap      = 1'b1;
                out_trap_insn = insn_q;
            end
            ST_REJECT: begin
                out_unsup = 1'b1;
            end
            default: begin
                out_wr_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/iadd_checker.sv
module iadd_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_flag_en,
    input logic            out_wr_en,
    input logic [XLEN-1:0] out_result,
    input logic            out_flag_we,
    input logic            out_sr_cy,
    input logic            out_sr_ov,
    input logic            out_sr_f,
    input logic            out_trap,
    input logic            out_unsup
);

    assert_trap_needs_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> (out_sr_ov && out_wr_en && out_flag_we));

    assert_write_or_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_unsup, out_wr_en}));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_wr_en && !out_unsup && !out_flag_we && !out_trap));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_flag_we |-> $stable({out_sr_cy, out_sr_ov, out_sr_f}));

    assert_write_updates_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> out_flag_we);

    assert_zero_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_flag_we && $past(in_flag_en) && (out_result == '0)) |-> out_sr_f);

endmodule

bind int_add_unit iadd_checker #(.XLEN(XLEN)) u_iadd_checker (.*);

// File: tb/tb_int_add_unit.sv
module tb_int_add_unit;

    typedef struct {
        logic        wr;
        logic [4:0]  rd;
        logic [31:0] res;
        logic        fwe;
        logic        cy;
        logic        ov;
        logic        f;
        logic        trap;
        logic [31:0] tinsn;
        logic        unsup;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_insn = '0;
    logic [31:0] in_opa = '0;
    logic [31:0] in_opb = '0;
    logic        in_sr_cy = 1'b0;
    logic        in_sr_f = 1'b0;
    logic        in_sr_ove = 1'b0;
    logic        in_flag_en = 1'b0;
    logic        out_wr_en;
    logic [4:0]  out_rd;
    logic [31:0] out_result;
    logic        out_flag_we;
    logic        out_sr_cy;
    logic        out_sr_ov;
    logic        out_sr_f;
    logic        out_trap;
    logic [31:0] out_trap_insn;
    logic        out_unsup;

    int checks = 0;
    int failures = 0;
    exp_t sb[$];
    logic m_cy = 1'b0;
    logic m_ov = 1'b0;
    logic m_f  = 1'b0;

    always #2 clk = ~clk;

    int_add_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_insn       (in_insn),
        .in_opa        (in_opa),
        .in_opb        (in_opb),
        .in_sr_cy      (in_sr_cy),
        .in_sr_f       (in_sr_f),
        .in_sr_ove     (in_sr_ove),
        .in_flag_en    (in_flag_en),
        .out_wr_en     (out_wr_en),
        .out_rd        (out_rd),
        .out_result    (out_result),
        .out_flag_we   (out_flag_we),
        .out_sr_cy     (out_sr_cy),
        .out_sr_ov     (out_sr_ov),
        .out_sr_f      (out_sr_f),
        .out_trap      (out_trap),
        .out_trap_insn (out_trap_insn),
        .out_unsup     (out_unsup)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rd, input logic [3:0] sub, input logic [1:0] hi);
        return {6'h38, rd, 5'd5, 5'd6, 1'b0, hi, 4'h0, sub};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rd, input logic [15:0] imm);
        return {op, rd, 5'd5, imm};
    endfunction

    task automatic cmp1(input string tag, input string what, input logic [31:0] act,
                        input logic [31:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
            bad = 1'b1;
        end
    endtask

    // Driver: one instruction, expectation from the requirements
    task automatic issue(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b,
                         input logic cy, input logic f, input logic ove, input logic fen,
                         input string tag);
        exp_t e;
        logic [5:0]  op;
        logic        is_add, is_imm, is_c;
        logic [31:0] opb;
        logic [32:0] wide;
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_opa = a; in_opb = b;
        in_sr_cy = cy; in_sr_f = f; in_sr_ove = ove; in_flag_en = fen;
        op     = insn[31:26];
        is_imm = (op == 6'h27) || (op == 6'h28);
        is_c   = (op == 6'h28) || (op == 6'h38 && insn[9:8] == 2'b00 && insn[3:0] == 4'h1);
        is_add = is_imm || (op == 6'h38 && insn[9:8] == 2'b00 && (insn[3:0] == 4'h0 || insn[3:0] == 4'h1));
        opb    = is_imm ? {{16{insn[15]}}, insn[15:0]} : b;
        wide   = {1'b0, a} + {1'b0, opb} + {32'd0, (is_c ? cy : 1'b0)};
        e.tag  = tag;
        e.unsup = !is_add;
        e.wr   = is_add;
        e.fwe  = is_add;
        e.rd   = insn[25:21];
        e.res  = wide[31:0];
        if (is_add) begin
            m_cy = wide[32];
            m_ov = (a[31] == opb[31]) && (wide[31] != a[31]);
            m_f  = fen ? (wide[31:0] == 32'd0) : f;
        end
        e.cy = m_cy; e.ov = m_ov; e.f = m_f;
        e.trap  = is_add && m_ov && ove;
        e.tinsn = e.trap ? insn : 32'd0;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            @(negedge clk);
            in_valid = 1'b0;
            in_insn  = 32'hFFFF_FFFF;
            in_sr_ove = 1'b1;
            e.tag = tag; e.wr = 1'b0; e.fwe = 1'b0; e.rd = '0; e.res = '0;
            e.cy = m_cy; e.ov = m_ov; e.f = m_f;
            e.trap = 1'b0; e.tinsn = '0; e.unsup = 1'b0;
            sb.push_back(e);
        end
    endtask

    // Monitor: each queued item is due one rising edge after it was driven
    always @(posedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            bit bad;
            #1;
            e = sb.pop_front();
            bad = 1'b0;
            checks++;
            cmp1(e.tag, "wr_en", {31'd0, out_wr_en}, {31'd0, e.wr}, bad);
            cmp1(e.tag, "flag_we", {31'd0, out_flag_we}, {31'd0, e.fwe}, bad);
            cmp1(e.tag, "unsup", {31'd0, out_unsup}, {31'd0, e.unsup}, bad);
            cmp1(e.tag, "trap", {31'd0, out_trap}, {31'd0, e.trap}, bad);
            cmp1(e.tag, "trap_insn", out_trap_insn, e.tinsn, bad);
            cmp1(e.tag, "cy", {31'd0, out_sr_cy}, {31'd0, e.cy}, bad);
            cmp1(e.tag, "ov", {31'd0, out_sr_ov}, {31'd0, e.ov}, bad);
            cmp1(e.tag, "f", {31'd0, out_sr_f}, {31'd0, e.f}, bad);
            if (e.wr) begin
                cmp1(e.tag, "rd", {27'd0, out_rd}, {27'd0, e.rd}, bad);
                cmp1(e.tag, "result", out_result, e.res, bad);
            end
            if (bad) failures++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] ADD, ADDC;
        ADD  = enc_r(5'd4, 4'h0, 2'b00);
        ADDC = enc_r(5'd4, 4'h1, 2'b00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        checks++;
        if ({out_wr_en, out_flag_we, out_trap, out_unsup, out_sr_cy, out_sr_ov, out_sr_f} !== 7'd0
            || out_result !== 32'd0 || out_rd !== 5'd0 || out_trap_insn !== 32'd0) begin
            failures++;
            $display("FAIL R10 reset outputs actual=0x%08h expected=0x00000000", out_result);
        end

        issue(ADD, 32'd1, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R1 add 1+2");
        issue(ADD, 32'd1, 32'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R3 add ignores carry");
        issue(enc_i(6'h27, 5'd9, 16'h0002), 32'd1, 32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 1'b0, "R3 addi ignores carry");
        issue(ADD, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b0, "R5 two small negatives");
        issue(ADD, 32'h4000_0000, 32'h3FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R4 no flags");
        issue(ADD, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R4 positive overflow");
        issue(ADD, 32'hC000_0000, 32'hC000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R5 carry only");
        issue(ADD, 32'hBFFF_FFFF, 32'hBFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R4 carry and overflow");
        issue(ADDC, 32'h4000_0000, 32'h3FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R4 overflow by carry-in");
        issue(ADDC, 32'hC000_0000, 32'hBFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R4 carry-in avoids overflow");
        issue(ADDC, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R5 ones+0+1");
        issue(ADDC, 32'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R5 0+ones+1");
        issue(ADDC, 32'd1, 32'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R3 addc carry clear");
        issue(enc_i(6'h28, 5'd7, 16'hFFFF), 32'd0, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 addic 0+ext(ffff)+1");
        issue(enc_i(6'h27, 5'd3, 16'h8000), 32'h8000_8000, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 addi ext 8000");
        issue(enc_i(6'h28, 5'd3, 16'h7FFF), 32'h7FFF_8000, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 addic overflow by carry");
        issue(enc_i(6'h27, 5'd31, 16'h8000), 32'h8000_7FFF, 32'd5, 1'b0, 1'b0, 1'b0, 1'b0, "R2 addi both flags");
        issue(ADD, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b1, 1'b0, "R7 overflow traps");
        issue(ADD, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b1, 1'b0, "R7 carry alone no trap");
        issue(enc_i(6'h28, 5'd2, 16'h3FFF), 32'h7FFF_C000, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R7 addic trap by carry");
        issue(ADDC, 32'hBFFF_FFFF, 32'hBFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R7 both flags trap");
        issue(ADD, 32'h4000_0000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R7 overflow without enable");
        issue(ADD, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 zero sets flag");
        issue(ADD, 32'd1, 32'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R6 nonzero clears flag");
        issue(ADD, 32'd1, 32'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R6 disabled passes flag in");
        issue(ADDC, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 R5 wrap to zero");
        idle(3, "R8 valid low");
        issue(enc_i(6'h39, 5'd4, 16'h0000), 32'h4000_0000, 32'h4000_0000, 1'b1, 1'b0, 1'b1, 1'b1, "R9 other opcode");
        issue(enc_r(5'd4, 4'h2, 2'b00), 32'd1, 32'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R9 other sub-op");
        issue(enc_r(5'd4, 4'h0, 2'b01), 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 R1 bits 9:8 set");
        issue(ADD, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 back to back after reject");
        idle(2, "R8 drain");
        wait (sb.size() == 0);
        repeat (2) @(posedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule